// File: doc/BRIEF.md
# Next-PC Misprediction Checker

This block judges, one instruction at a time, whether the next PC chosen by fetch was right. Fetch gives a guess for every instruction, control or not. The block takes the instruction's own PC, the PC that fetch went to next, the decoded instruction class and the resolved outcome (taken flag and target). From these it works out what the correct next PC was and whether fetch got it.

The direction fetch assumed is taken from the guess itself. A guess equal to PC+4 is a not-taken guess, and any other value is a taken guess. Each of the two kinds has its own rules for when it counts as wrong. On a wrong guess the block sends out a one-cycle mispredict pulse and a redirect PC. For every checked control instruction it also sends out a training record for the predictor tables. It is meant to sit at the point where instructions become non-speculative, normally commit. Every output is registered and appears one clock after the checked input.

Top module: `npc_verdict`

## Requirements
- R1: While reset is high, and on the first clock edge after reset is released, `flag_mispredict` and `train_valid` are 0. `redirect_pc`, `train_pc` and `train_target` are 0, and `train_taken` is 0.
- R2: A check whose `chk_valid` is low makes `flag_mispredict` and `train_valid` 0 on the next cycle, whatever the other inputs carry.
- R3: Class encoding: 2'b00 non-control, 2'b01 conditional branch, 2'b10 jump, 2'b11 treated as non-control. A guess is "taken" when `guess_pc` differs from `chk_pc + 4` (modulo 2^32), and "not taken" otherwise.
- R4: A taken guess is flagged wrong when the class is non-control. It is also flagged wrong for a conditional branch that resolves not taken.
- R5: A taken guess on a jump, or on a conditional branch that resolves taken, is flagged wrong exactly when `guess_pc` differs from `res_target`.
- R6: A not-taken guess is flagged wrong for every jump, and for a conditional branch that resolves taken. It is never wrong for non-control instructions or for branches that resolve not taken.
- R7: When a mispredict is flagged, `redirect_pc` is `res_target` if the instruction actually transfers control (jump, or branch resolved taken). Otherwise it is `chk_pc + 4`.
- R8: Every valid check of a branch or jump raises `train_valid` for one cycle, whether or not it was mispredicted. The record is `train_pc` = `chk_pc`, `train_taken` = 1 for a jump or a taken branch, and `train_target` = `res_target`. Non-control checks raise no record.
- R9: All outputs appear exactly one clock after the check, and back-to-back valid checks each produce their own independent result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_valid | input | 1 | A check is presented this cycle |
| chk_pc | input | 32 | PC of the checked instruction |
| guess_pc | input | 32 | Next PC that fetch used after it |
| chk_class | input | 2 | 00 non-control, 01 branch, 10 jump, 11 non-control |
| res_taken | input | 1 | Resolved direction for a branch |
| res_target | input | 32 | Resolved target address |
| flag_mispredict | output | 1 | One-cycle pulse on a wrong guess |
| redirect_pc | output | 32 | Correct next PC, meaningful with flag_mispredict |
| train_valid | output | 1 | Training record present |
| train_pc | output | 32 | Training record: instruction PC |
| train_taken | output | 1 | Training record: actual direction |
| train_target | output | 32 | Training record: resolved target |

## Verification
The hardest situation to reach is a taken guess on a taken control instruction where only the target is wrong. This is the case of R5. Random 32-bit targets almost never equal a guess that is also not PC+4. For that reason the random generator often copies `res_target` into `guess_pc`, and then sometimes flips one low bit of it. Directed checks also cover PC+4 wrap-around at the top of the address space, and a jump whose target is exactly PC+4. That jump case reads as a not-taken guess and must still be flagged.

// File: rtl/npc_verdict_pkg.sv
package npc_verdict_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned INSN_BYTES = 4;
  typedef enum logic [1:0] {
    CLS_PLAIN  = 2'b00,
    CLS_BRANCH = 2'b01,
    CLS_JUMP   = 2'b10,
    CLS_RSVD   = 2'b11
  } insn_class_e;
endpackage

// File: rtl/npc_classify.sv
module npc_classify
  import npc_verdict_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned STEP = INSN_BYTES
) (
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] guess,
  input  logic [1:0]    cls,
  input  logic          taken_in,
  output logic [AW-1:0] seq_pc,
  output logic          guess_taken,
  output logic          is_ctrl,
  output logic          actual_taken
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);
  always_comb begin
    seq_pc       = pc + STEP_V;
    guess_taken  = (guess != seq_pc);
    is_ctrl      = (cls == CLS_BRANCH) || (cls == CLS_JUMP);
    actual_taken = (cls == CLS_JUMP) || ((cls == CLS_BRANCH) && taken_in);
  end
endmodule

// File: rtl/npc_rules.sv
module npc_rules
  import npc_verdict_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic [AW-1:0] guess,
  input  logic [AW-1:0] target,
  input  logic [AW-1:0] seq_pc,
  input  logic [1:0]    cls,
  input  logic          guess_taken,
  input  logic          actual_taken,
  output logic          wrong,
  output logic [AW-1:0] fix_pc
);
  logic wrong_t, wrong_nt;
  always_comb begin
    // taken-guess rules
    if (cls == CLS_PLAIN || cls == CLS_RSVD) wrong_t = 1'b1;
    else if (!actual_taken)                  wrong_t = 1'b1;
    else                                     wrong_t = (guess != target);
    // not-taken-guess rules
    wrong_nt = actual_taken;
    wrong    = guess_taken ? wrong_t : wrong_nt;
    fix_pc   = actual_taken ? target : seq_pc;
  end
endmodule

// File: rtl/npc_verdict.sv
module npc_verdict
  import npc_verdict_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned STEP = INSN_BYTES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chk_valid,
  input  logic [31:0]   chk_pc,
  input  logic [31:0]   guess_pc,
  input  logic [1:0]    chk_class,
  input  logic          res_taken,
  input  logic [31:0]   res_target,
  output logic          flag_mispredict,
  output logic [31:0]   redirect_pc,
  output logic          train_valid,
  output logic [31:0]   train_pc,
  output logic          train_taken,
  output logic [31:0]   train_target
);
  logic [AW-1:0] seq_pc, fix_pc;
  logic guess_taken, is_ctrl, actual_taken, wrong;

  npc_classify #(.AW(AW), .STEP(STEP)) u_cls (
    .pc(chk_pc), .guess(guess_pc), .cls(chk_class), .taken_in(res_taken),
    .seq_pc(seq_pc), .guess_taken(guess_taken), .is_ctrl(is_ctrl),
    .actual_taken(actual_taken)
  );

  npc_rules #(.AW(AW)) u_rules (
    .guess(guess_pc), .target(res_target), .seq_pc(seq_pc), .cls(chk_class),
    .guess_taken(guess_taken), .actual_taken(actual_taken),
    .wrong(wrong), .fix_pc(fix_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_mispredict <= 1'b0;
      redirect_pc     <= '0;
      train_valid     <= 1'b0;
      train_pc        <= '0;
      train_taken     <= 1'b0;
      train_target    <= '0;
    end else begin
      flag_mispredict <= chk_valid && wrong;
      redirect_pc     <= fix_pc;
      train_valid     <= chk_valid && is_ctrl;
      train_pc        <= chk_pc;
      train_taken     <= actual_taken;
      train_target    <= res_target;
    end
  end

  // R2: no output activity after an invalid check
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !chk_valid |=> (!flag_mispredict && !train_valid));
  // R6: a not-taken guess on non-control never flags
  p_nt_plain_ok_r6: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && guess_pc == chk_pc + 32'd4 && chk_class[1] == chk_class[0])
    |=> !flag_mispredict);
  // R4: a taken guess on non-control always flags
  p_t_plain_bad_r4: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && guess_pc != chk_pc + 32'd4 && chk_class[1] == chk_class[0])
    |=> flag_mispredict);
  // R8: records only for control classes, carrying the checked PC
  p_train_pc_r8: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && chk_class[1] != chk_class[0]) |=> (train_valid && train_pc == $past(chk_pc)));
  // R7: jump redirect goes to the resolved target
  p_jump_redirect_r7: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && chk_class == 2'b10) |=> (redirect_pc == $past(res_target)));
  // R6: a not-taken guess on a jump always flags
  p_nt_jump_bad_r6: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && chk_class == 2'b10 && guess_pc == chk_pc + 32'd4) |=> flag_mispredict);
endmodule

// File: tb/npc_verdict_bench.sv
module npc_verdict_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic chk_valid = 1'b0;
  logic [31:0] chk_pc = '0, guess_pc = '0, res_target = '0;
  logic [1:0] chk_class = '0;
  logic res_taken = 1'b0;
  logic flag_mispredict, train_valid, train_taken;
  logic [31:0] redirect_pc, train_pc, train_target;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  npc_verdict u_npc_verdict (.*);

  function automatic logic exp_wrong(logic [31:0] pc, logic [31:0] g, logic [1:0] c,
                                     logic tk, logic [31:0] tg);
    logic act = (c == 2'b10) || (c == 2'b01 && tk);
    if (g != pc + 32'd4) begin
      if (c == 2'b00 || c == 2'b11) return 1'b1;
      if (!act) return 1'b1;
      return g != tg;
    end
    return act;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one check, then sample its result at the falling edge after the edge
  task automatic run(logic v, logic [31:0] pc, logic [31:0] g, logic [1:0] c,
                     logic tk, logic [31:0] tg);
    logic w, ctl, act;
    chk_valid = v; chk_pc = pc; guess_pc = g; chk_class = c; res_taken = tk; res_target = tg;
    w = exp_wrong(pc, g, c, tk, tg);
    ctl = (c == 2'b01) || (c == 2'b10);
    act = (c == 2'b10) || (c == 2'b01 && tk);
    @(posedge clk); @(negedge clk);
    chk("R9 mispredict", {31'b0, flag_mispredict}, {31'b0, v && w});
    if (v && w) chk("R7 redirect", redirect_pc, act ? tg : pc + 32'd4);
    chk("R8 train_valid", {31'b0, train_valid}, {31'b0, v && ctl});
    if (v && ctl) begin
      chk("R8 train_pc", train_pc, pc);
      chk("R8 train_taken", {31'b0, train_taken}, {31'b0, act});
      chk("R8 train_target", train_target, tg);
    end
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 flag", {31'b0, flag_mispredict}, 32'd0);
    chk("R1 train_valid", {31'b0, train_valid}, 32'd0);
    chk("R1 redirect", redirect_pc, 32'd0);
    chk("R1 train_pc", train_pc, 32'd0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R1 after release", {30'b0, flag_mispredict, train_valid}, 32'd0);
    // R2: invalid with a wrong-looking guess
    run(1'b0, 32'h100, 32'h900, 2'b10, 1'b1, 32'h400);
    // R3/R4: non-control with taken guess, and reserved class
    run(1'b1, 32'h200, 32'h300, 2'b00, 1'b0, 32'h0);
    run(1'b1, 32'h200, 32'h300, 2'b11, 1'b0, 32'h0);
    // R4: branch resolves not taken under taken guess
    run(1'b1, 32'h200, 32'h800, 2'b01, 1'b0, 32'h800);
    // R5: correct taken, then wrong target
    run(1'b1, 32'h200, 32'h800, 2'b01, 1'b1, 32'h800);
    run(1'b1, 32'h200, 32'h804, 2'b10, 1'b1, 32'h800);
    // R6: not-taken guess on jump whose target is pc+4
    run(1'b1, 32'h200, 32'h204, 2'b10, 1'b0, 32'h204);
    run(1'b1, 32'h200, 32'h204, 2'b01, 1'b1, 32'h600);
    run(1'b1, 32'h200, 32'h204, 2'b01, 1'b0, 32'h600);
    run(1'b1, 32'h200, 32'h204, 2'b00, 1'b0, 32'h600);
    // R3: wrap at top of address space
    run(1'b1, 32'hFFFF_FFFC, 32'h0, 2'b00, 1'b0, 32'h10);
    run(1'b1, 32'hFFFF_FFFC, 32'h4, 2'b00, 1'b0, 32'h10);
    // R9: random back-to-back
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] pc, g, tg;
      logic [1:0] c;
      int sel;
      pc = {$urandom() & 32'h0000_FFFF} << 2;
      tg = {$urandom() & 32'h0000_FFFF} << 2;
      c = 2'($urandom());
      sel = $urandom_range(0, 3);
      if (sel == 0) g = pc + 32'd4;
      else if (sel == 1) g = tg;
      else if (sel == 2) g = tg ^ 32'h4;
      else g = $urandom() & ~32'h3;
      run($urandom_range(0, 7) != 0, pc, g, c, 1'($urandom()), tg);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule